// File: doc/BRIEF.md
# Per-Bank DRAM Command Timing Guard

This block watches the command stream that a scheduler places on a four-bank DRAM command bus. For every bank it keeps an open/closed state and a set of down-counters that hold the minimum spacing still owed before the next activate, read, write or precharge. From those counters it produces per-bank permission signals, a permission for an all-bank refresh, and a periodic refresh request. The scheduler consults the permissions before issuing; the guard sets a violation flag one cycle after any command that breaks a rule.

All minimum times are given as picosecond parameters and converted to clock counts by rounding up against the clock period. The activate-to-write delay is derived from the activate-to-read delay. The write recovery used with auto-precharge is derived from the read latency. A flagged command is treated as never having happened, so a scheduler error cannot corrupt the tracked timing.

Top module: `bank_timing_guard`

## Requirements
- R1: After reset every bank is closed, all activate and precharge permissions and the refresh permission are high, read and write permissions are low, and neither the violation flag nor the refresh request is set.
- R2: An accepted activate opens its bank. An activate to an open bank is flagged, and so is a read or a write to a closed bank.
- R3: A read needs tRCDRD clocks after the activate of its bank. A write needs tRCDWR clocks, where tRCDWR = max(tRCDRD - 2, 2).
- R4: For one bank, activate-to-activate needs tRC, activate-to-precharge needs tRAS, and precharge-to-activate needs tRP. A precharge closes the bank.
- R5: Activates to any two banks are at least tRRD clocks apart.
- R6: A read needs write latency + burst/2 + tCDLR clocks after the last write. Column commands are at least tCCD apart.
- R7: A plain write delays precharge of its bank by write latency + burst/2 + tWR. A write with auto-precharge closes the bank and delays its next activate by write latency + burst/2 + tDAL, where tDAL = (CL + 1) + tRP.
- R8: A read with auto-precharge closes the bank. Its next activate waits max(remaining tRAS, burst/2) + tRP clocks.
- R9: Refresh is permitted only when all banks are closed and their activate counters are zero. An activate to any bank needs tRFC clocks after a refresh.
- R10: The refresh request is high for exactly one cycle. It first rises tREFI - 1 cycles after reset, and again tREFI - 1 cycles after each pulse or after each accepted refresh command. tREFI is 7.8 us in clocks.
- R11: cmd_op codes are 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh. The flag viol is high in the cycle after a command that breaks R2 to R9 and low otherwise. A flagged command changes no state.
- R12: Every picosecond minimum becomes ceil(time / clock period) clocks; with the defaults tRAS 28.6 ns at 2.5 ns gives 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is on the bus this cycle |
| cmd_op | input | 3 | Command code (R11) |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| cmd_autopre | input | 1 | Read or write closes the bank afterwards |
| may_act | output | NUM_BANKS | Activate permitted per bank |
| may_rd | output | NUM_BANKS | Read permitted per bank |
| may_wr | output | NUM_BANKS | Write permitted per bank |
| may_pre | output | NUM_BANKS | Precharge permitted per bank |
| may_ref | output | 1 | All-bank refresh permitted |
| bank_open | output | NUM_BANKS | Bank holds an open row |
| ref_req | output | 1 | One-cycle refresh request pulse |
| viol | output | 1 | Previous cycle's command broke a rule |

## Verification
A command sampled at edge E loads its counters at E, so the permissions move in the cycle that follows E. The flag viol is registered and is read at the falling edge after E. A spacing of N clocks therefore makes a command at E+N legal and a command at E+N-1 flagged. The bench issues both sides of each bound and places each command by its absolute edge number. The refresh pulse is counted in whole cycles from the release of reset and from the accepted refresh, and is sampled between edges.

// File: rtl/btg_pkg.sv
package btg_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5
  } btg_op_e;

  // Minimum time in picoseconds to clocks, always rounding up.
  function automatic int ps_to_clk(input int t_ps, input int tck_ps);
    return (t_ps + tck_ps - 1) / tck_ps;
  endfunction

  // Activate-to-write delay is two clocks shorter than activate-to-read, floor of two.
  function automatic int rcdwr_of(input int rcdrd);
    return (rcdrd - 2 < 2) ? 2 : rcdrd - 2;
  endfunction

  // Write recovery under auto-precharge is tied to read latency.
  function automatic int wr_ap_of(input int cas_lat);
    return cas_lat + 1;
  endfunction

  // A spacing of n clocks loads n-1 into a counter that is read before it moves.
  function automatic int load_of(input int n);
    return (n < 1) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/btg_bank.sv
module btg_bank #(
  parameter int CNT_W    = 6,
  parameter int LD_RC    = 17,
  parameter int LD_RAS   = 11,
  parameter int LD_RCDRD = 5,
  parameter int LD_RCDWR = 3,
  parameter int LD_RP    = 5,
  parameter int LD_RFC   = 19,
  parameter int LD_WRPRE = 8,
  parameter int LD_WRAP  = 14,
  parameter int RD_PRE   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic do_rd,
  input  logic do_wr,
  input  logic do_pre,
  input  logic do_ref,
  input  logic autopre,
  output logic is_open,
  output logic act_zero,
  output logic ras_zero,
  output logic rd_zero,
  output logic wr_zero
);

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t dn(input cnt_t v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic cnt_t mx(input cnt_t a, input cnt_t b);
    return (a > b) ? a : b;
  endfunction

  cnt_t act_q, ras_q, rd_q, wr_q;
  cnt_t act_d, ras_d, rd_d, wr_d;
  logic open_q, open_d;

  always_comb begin
    act_d  = dn(act_q);
    ras_d  = dn(ras_q);
    rd_d   = dn(rd_q);
    wr_d   = dn(wr_q);
    open_d = open_q;
    if (do_act) begin
      open_d = 1'b1;
      act_d  = mx(act_d, cnt_t'(LD_RC));
      ras_d  = mx(ras_d, cnt_t'(LD_RAS));
      rd_d   = cnt_t'(LD_RCDRD);
      wr_d   = cnt_t'(LD_RCDWR);
    end
    if (do_rd) begin
      ras_d = mx(ras_d, cnt_t'(RD_PRE - 1));
      if (autopre) begin
        open_d = 1'b0;
        act_d  = mx(act_d, mx(ras_q, cnt_t'(RD_PRE)) + cnt_t'(LD_RP));
      end
    end
    if (do_wr) begin
      if (autopre) begin
        open_d = 1'b0;
        act_d  = mx(act_d, cnt_t'(LD_WRAP));
      end else begin
        ras_d = mx(ras_d, cnt_t'(LD_WRPRE));
      end
    end
    if (do_pre && open_q) begin
      open_d = 1'b0;
      act_d  = mx(act_d, cnt_t'(LD_RP));
    end
    if (do_ref) begin
      act_d = mx(act_d, cnt_t'(LD_RFC));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      ras_q  <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      open_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      ras_q  <= ras_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      open_q <= open_d;
    end
  end

  assign is_open  = open_q;
  assign act_zero = (act_q == '0);
  assign ras_zero = (ras_q == '0);
  assign rd_zero  = (rd_q == '0);
  assign wr_zero  = (wr_q == '0);

endmodule

// File: rtl/btg_shared.sv
module btg_shared #(
  parameter int CNT_W   = 6,
  parameter int LD_RRD  = 3,
  parameter int LD_CCD  = 0,
  parameter int LD_W2R  = 4,
  parameter int REFI_W  = 12,
  parameter int LD_REFI = 3119
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_any,
  input  logic col_any,
  input  logic wr_any,
  input  logic ref_any,
  output logic rrd_ok,
  output logic ccd_ok,
  output logic w2r_ok,
  output logic ref_req
);

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t dn(input cnt_t v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  cnt_t rrd_q, ccd_q, w2r_q;
  logic [REFI_W-1:0] refi_q;
  logic refi_done;

  assign refi_done = (refi_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_q  <= '0;
      ccd_q  <= '0;
      w2r_q  <= '0;
      refi_q <= REFI_W'(LD_REFI);
    end else begin
      rrd_q  <= act_any ? cnt_t'(LD_RRD) : dn(rrd_q);
      ccd_q  <= col_any ? cnt_t'(LD_CCD) : dn(ccd_q);
      w2r_q  <= wr_any  ? cnt_t'(LD_W2R) : dn(w2r_q);
      refi_q <= (ref_any || refi_done) ? REFI_W'(LD_REFI) : refi_q - 1'b1;
    end
  end

  assign rrd_ok  = (rrd_q == '0);
  assign ccd_ok  = (ccd_q == '0);
  assign w2r_ok  = (w2r_q == '0);
  assign ref_req = refi_done;

endmodule

// File: rtl/btg_decode.sv
module btg_decode #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [BA_W-1:0]      cmd_bank,
  input  logic [NUM_BANKS-1:0] may_act,
  input  logic [NUM_BANKS-1:0] may_rd,
  input  logic [NUM_BANKS-1:0] may_wr,
  input  logic [NUM_BANKS-1:0] may_pre,
  input  logic                 may_ref,
  output logic [NUM_BANKS-1:0] act_go,
  output logic [NUM_BANKS-1:0] rd_go,
  output logic [NUM_BANKS-1:0] wr_go,
  output logic [NUM_BANKS-1:0] pre_go,
  output logic                 ref_go,
  output logic                 bad
);

  import btg_pkg::*;

  btg_op_e op;
  logic is_act, is_rd, is_wr, is_pre, is_ref, ok;

  assign op     = btg_op_e'(cmd_op);
  assign is_act = cmd_valid && (op == OP_ACT);
  assign is_rd  = cmd_valid && (op == OP_RD);
  assign is_wr  = cmd_valid && (op == OP_WR);
  assign is_pre = cmd_valid && (op == OP_PRE);
  assign is_ref = cmd_valid && (op == OP_REF);

  assign bad = (is_act && !may_act[cmd_bank]) ||
               (is_rd  && !may_rd[cmd_bank])  ||
               (is_wr  && !may_wr[cmd_bank])  ||
               (is_pre && !may_pre[cmd_bank]) ||
               (is_ref && !may_ref);
  assign ok  = !bad;
  assign ref_go = is_ref && ok;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      act_go[b] = is_act && ok && (cmd_bank == BA_W'(b));
      rd_go[b]  = is_rd  && ok && (cmd_bank == BA_W'(b));
      wr_go[b]  = is_wr  && ok && (cmd_bank == BA_W'(b));
      pre_go[b] = is_pre && ok && (cmd_bank == BA_W'(b));
    end
  end

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard #(
  parameter int NUM_BANKS  = 4,
  parameter int T_CK_PS    = 2500,
  parameter int T_RC_PS    = 45000,
  parameter int T_RFC_PS   = 50000,
  parameter int T_RAS_PS   = 28600,
  parameter int T_RCDRD_PS = 15000,
  parameter int T_RP_PS    = 15000,
  parameter int T_RRD_PS   = 10000,
  parameter int T_WR_PS    = 15000,
  parameter int T_REFI_PS  = 7800000,
  parameter int CAS_LAT    = 5,
  parameter int WR_LAT     = 1,
  parameter int BURST_LEN  = 4,
  parameter int T_CCD      = 1,
  parameter int T_CDLR     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input  logic                         cmd_autopre,
  output logic [NUM_BANKS-1:0]         may_act,
  output logic [NUM_BANKS-1:0]         may_rd,
  output logic [NUM_BANKS-1:0]         may_wr,
  output logic [NUM_BANKS-1:0]         may_pre,
  output logic                         may_ref,
  output logic [NUM_BANKS-1:0]         bank_open,
  output logic                         ref_req,
  output logic                         viol
);

  import btg_pkg::*;

  localparam int BA_W     = $clog2(NUM_BANKS);
  localparam int K_RC     = ps_to_clk(T_RC_PS, T_CK_PS);
  localparam int K_RFC    = ps_to_clk(T_RFC_PS, T_CK_PS);
  localparam int K_RAS    = ps_to_clk(T_RAS_PS, T_CK_PS);
  localparam int K_RCDRD  = ps_to_clk(T_RCDRD_PS, T_CK_PS);
  localparam int K_RCDWR  = rcdwr_of(K_RCDRD);
  localparam int K_RP     = ps_to_clk(T_RP_PS, T_CK_PS);
  localparam int K_RRD    = ps_to_clk(T_RRD_PS, T_CK_PS);
  localparam int K_WR     = ps_to_clk(T_WR_PS, T_CK_PS);
  localparam int K_DAL    = wr_ap_of(CAS_LAT) + K_RP;
  localparam int K_REFI   = ps_to_clk(T_REFI_PS, T_CK_PS);
  localparam int WR_BURST = WR_LAT + BURST_LEN / 2;
  localparam int RD_PRE   = BURST_LEN / 2;
  localparam int CNT_W    = $clog2(K_RFC + K_RC + K_RAS + K_RP + K_DAL + WR_BURST + RD_PRE + 1);
  localparam int REFI_W   = $clog2(K_REFI + 1);

  logic [NUM_BANKS-1:0] act_go, rd_go, wr_go, pre_go;
  logic [NUM_BANKS-1:0] act_zero, ras_zero, rd_zero, wr_zero;
  logic ref_go, cmd_bad;
  logic rrd_ok, ccd_ok, w2r_ok;
  logic viol_q;

  btg_decode #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) u_decode (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .may_act   (may_act),
    .may_rd    (may_rd),
    .may_wr    (may_wr),
    .may_pre   (may_pre),
    .may_ref   (may_ref),
    .act_go    (act_go),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .pre_go    (pre_go),
    .ref_go    (ref_go),
    .bad       (cmd_bad)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    btg_bank #(
      .CNT_W    (CNT_W),
      .LD_RC    (load_of(K_RC)),
      .LD_RAS   (load_of(K_RAS)),
      .LD_RCDRD (load_of(K_RCDRD)),
      .LD_RCDWR (load_of(K_RCDWR)),
      .LD_RP    (load_of(K_RP)),
      .LD_RFC   (load_of(K_RFC)),
      .LD_WRPRE (load_of(WR_BURST + K_WR)),
      .LD_WRAP  (load_of(WR_BURST + K_DAL)),
      .RD_PRE   (RD_PRE)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_act   (act_go[b]),
      .do_rd    (rd_go[b]),
      .do_wr    (wr_go[b]),
      .do_pre   (pre_go[b]),
      .do_ref   (ref_go),
      .autopre  (cmd_autopre),
      .is_open  (bank_open[b]),
      .act_zero (act_zero[b]),
      .ras_zero (ras_zero[b]),
      .rd_zero  (rd_zero[b]),
      .wr_zero  (wr_zero[b])
    );

    assign may_act[b] = !bank_open[b] && act_zero[b] && rrd_ok;
    assign may_rd[b]  = bank_open[b] && rd_zero[b] && ccd_ok && w2r_ok;
    assign may_wr[b]  = bank_open[b] && wr_zero[b] && ccd_ok;
    assign may_pre[b] = ras_zero[b];
  end

  btg_shared #(
    .CNT_W   (CNT_W),
    .LD_RRD  (load_of(K_RRD)),
    .LD_CCD  (load_of(T_CCD)),
    .LD_W2R  (load_of(WR_BURST + T_CDLR)),
    .REFI_W  (REFI_W),
    .LD_REFI (load_of(K_REFI))
  ) u_shared (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_any (|act_go),
    .col_any ((|rd_go) || (|wr_go)),
    .wr_any  (|wr_go),
    .ref_any (ref_go),
    .rrd_ok  (rrd_ok),
    .ccd_ok  (ccd_ok),
    .w2r_ok  (w2r_ok),
    .ref_req (ref_req)
  );

  assign may_ref = (bank_open == '0) && (&act_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= cmd_bad;
  end

  assign viol = viol_q;

endmodule

// File: rtl/btg_checker.sv
module btg_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_valid,
  input logic [2:0]                   cmd_op,
  input logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input logic [NUM_BANKS-1:0]         may_act,
  input logic [NUM_BANKS-1:0]         may_rd,
  input logic [NUM_BANKS-1:0]         may_wr,
  input logic [NUM_BANKS-1:0]         may_pre,
  input logic                         may_ref,
  input logic [NUM_BANKS-1:0]         bank_open,
  input logic                         ref_req,
  input logic                         viol
);

  import btg_pkg::*;

  // R2
  closed_col_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && !bank_open[cmd_bank] |=> viol);

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_ACT && may_act[cmd_bank]
    |=> bank_open[$past(cmd_bank)] && !may_act[$past(cmd_bank)]);

  // R3
  act_blocks_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_ACT && may_act[cmd_bank]
    |=> !may_rd[$past(cmd_bank)] && !may_wr[$past(cmd_bank)]);

  // R4
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PRE && may_pre[cmd_bank] |=> !bank_open[$past(cmd_bank)]);

  // R9
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    may_ref |-> (bank_open == '0));

  // R10
  ref_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |=> !ref_req);

  // R11
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !viol);

  // R11
  legal_act_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_ACT && may_act[cmd_bank] |=> !viol);

endmodule

bind bank_timing_guard btg_checker #(.NUM_BANKS(NUM_BANKS)) u_btg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_bank  (cmd_bank),
  .may_act   (may_act),
  .may_rd    (may_rd),
  .may_wr    (may_wr),
  .may_pre   (may_pre),
  .may_ref   (may_ref),
  .bank_open (bank_open),
  .ref_req   (ref_req),
  .viol      (viol)
);

// File: tb/bank_timing_guard_bench.sv
module bank_timing_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TCK = 2500;
  // R12: clocks are ceil(ps / period), written here as an integer division with a remainder test
  localparam int K_RC    = 45000 / TCK + ((45000 % TCK) != 0 ? 1 : 0);
  localparam int K_RFC   = 50000 / TCK + ((50000 % TCK) != 0 ? 1 : 0);
  localparam int K_RAS   = 28600 / TCK + ((28600 % TCK) != 0 ? 1 : 0);
  localparam int K_RCDRD = 15000 / TCK + ((15000 % TCK) != 0 ? 1 : 0);
  localparam int K_RP    = 15000 / TCK + ((15000 % TCK) != 0 ? 1 : 0);
  localparam int K_RRD   = 10000 / TCK + ((10000 % TCK) != 0 ? 1 : 0);
  localparam int K_WR    = 15000 / TCK + ((15000 % TCK) != 0 ? 1 : 0);
  localparam int K_REFI  = 7800000 / TCK + ((7800000 % TCK) != 0 ? 1 : 0);
  localparam int K_RCDWR = (K_RCDRD > 4) ? K_RCDRD - 2 : 2;
  localparam int K_DAL   = 5 + 1 + K_RP;
  localparam int WRB     = 1 + 4 / 2;
  localparam int W2R     = WRB + 2;
  localparam int PRE_WR  = WRB + K_WR;

  // absolute command edges of the table walk
  localparam int E_W  = K_RCDWR;
  localparam int E_R  = E_W + W2R;
  localparam int E_P  = E_W + PRE_WR;
  localparam int E_A  = E_P + K_RP;
  localparam int E_B  = E_A + K_RRD;
  localparam int E_RA = E_B + K_RCDRD;
  localparam int E_C  = E_B + K_RC;
  localparam int E_WA = E_C + 1;
  localparam int E_D  = E_WA + WRB + K_DAL;

  typedef struct packed {
    logic [7:0] at;
    logic [2:0] op;
    logic [1:0] bank;
    logic       ap;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{8'(0),        3'd1, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 open bank 0
    '{8'(E_W - 1),  3'd3, 2'd0, 1'b0, 1'b1, 4'd3},  // R3 write too early
    '{8'(E_W),      3'd3, 2'd0, 1'b0, 1'b0, 4'd3},  // R3 write at tRCDWR
    '{8'(E_R - 1),  3'd2, 2'd0, 1'b0, 1'b1, 4'd6},  // R6 read too soon after write
    '{8'(E_R),      3'd2, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 read at write-to-read bound
    '{8'(E_P - 1),  3'd4, 2'd0, 1'b0, 1'b1, 4'd7},  // R7 precharge before recovery
    '{8'(E_P),      3'd4, 2'd0, 1'b0, 1'b0, 4'd7},  // R7 precharge after recovery
    '{8'(E_A - 1),  3'd1, 2'd0, 1'b0, 1'b1, 4'd4},  // R4 activate inside tRP
    '{8'(E_A),      3'd1, 2'd0, 1'b0, 1'b0, 4'd4},  // R4 activate after tRP
    '{8'(E_B - 1),  3'd1, 2'd1, 1'b0, 1'b1, 4'd5},  // R5 other bank inside tRRD
    '{8'(E_B),      3'd1, 2'd1, 1'b0, 1'b0, 4'd5},  // R5 other bank at tRRD
    '{8'(E_B + 1),  3'd1, 2'd1, 1'b0, 1'b1, 4'd2},  // R2 activate to open bank
    '{8'(E_B + 2),  3'd2, 2'd2, 1'b0, 1'b1, 4'd2},  // R2 read to closed bank
    '{8'(E_RA - 1), 3'd2, 2'd1, 1'b1, 1'b1, 4'd3},  // R3 read inside tRCDRD (also R11: no state change)
    '{8'(E_RA),     3'd2, 2'd1, 1'b1, 1'b0, 4'd8},  // R8 read with auto-precharge
    '{8'(E_RA + 1), 3'd2, 2'd1, 1'b0, 1'b1, 4'd8},  // R8 bank now closed
    '{8'(E_C - 1),  3'd1, 2'd1, 1'b0, 1'b1, 4'd8},  // R8 activate before auto-precharge done
    '{8'(E_C),      3'd1, 2'd1, 1'b0, 1'b0, 4'd4},  // R4 activate at tRC
    '{8'(E_WA),     3'd3, 2'd0, 1'b1, 1'b0, 4'd7},  // R7 write with auto-precharge
    '{8'(E_D - 1),  3'd1, 2'd0, 1'b0, 1'b1, 4'd7},  // R7 activate inside tDAL window
    '{8'(E_D),      3'd1, 2'd0, 1'b0, 1'b0, 4'd7}   // R7 activate after tDAL window
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic cmd_autopre = 1'b0;
  logic [3:0] may_act, may_rd, may_wr, may_pre, bank_open;
  logic may_ref, ref_req, viol;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bank_timing_guard u_bank_timing_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cmd_autopre (cmd_autopre),
    .may_act     (may_act),
    .may_rd      (may_rd),
    .may_wr      (may_wr),
    .may_pre     (may_pre),
    .may_ref     (may_ref),
    .bank_open   (bank_open),
    .ref_req     (ref_req),
    .viol        (viol)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // wait gap idle edges, drive one command on the next edge, then read viol
  task automatic issue(input int gap, input logic [2:0] op, input logic [1:0] bank,
                       input logic ap, input logic exp, input string req);
    repeat (gap) tick();
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank; cmd_autopre = ap;
    tick();
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_autopre = 1'b0;
    chk(req, {31'd0, viol}, {31'd0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  task automatic count_to_pulse(input string req);
    int n = 0;
    while (ref_req !== 1'b1 && n < 2 * K_REFI) begin
      tick();
      n++;
    end
    chk(req, n, K_REFI - 1);
    tick();
    chk({req, " width"}, {31'd0, ref_req}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 may_act", may_act, 32'hF);
    chk("R1 may_pre", may_pre, 32'hF);
    chk("R1 may_rd", may_rd, 32'h0);
    chk("R1 may_wr", may_wr, 32'h0);
    chk("R1 may_ref", may_ref, 32'h1);
    chk("R1 bank_open", bank_open, 32'h0);
    chk("R1 viol", viol, 32'h0);
    chk("R1 ref_req", ref_req, 32'h0);

    begin
      int prev = -1;
      for (int i = 0; i < NV; i++) begin
        issue(int'(VEC[i].at) - prev - 1, VEC[i].op, VEC[i].bank, VEC[i].ap, VEC[i].exp,
              $sformatf("R%0d table row %0d", VEC[i].req, i));
        prev = int'(VEC[i].at);
      end
    end
    // R9 refresh while banks are open
    issue(0, 3'd5, 2'd0, 1'b0, 1'b1, "R9 refresh with open banks");

    // R9 close everything, then refresh at the tRP bound
    issue(20, 3'd4, 2'd0, 1'b0, 1'b0, "R4 precharge bank 0");
    issue(0, 3'd4, 2'd1, 1'b0, 1'b0, "R4 precharge bank 1");
    chk("R9 may_ref inside tRP", may_ref, 32'h0);
    chk("R4 banks closed", bank_open, 32'h0);
    issue(K_RP - 2, 3'd5, 2'd0, 1'b0, 1'b1, "R9 refresh inside tRP");
    issue(0, 3'd5, 2'd0, 1'b0, 1'b0, "R9 refresh at tRP");
    issue(K_RFC - 2, 3'd1, 2'd2, 1'b0, 1'b1, "R9 activate inside tRFC");
    issue(0, 3'd1, 2'd2, 1'b0, 1'b0, "R9 activate at tRFC");
    chk("R2 bank 2 open", bank_open[2], 32'h1);
    chk("R3 read blocked after activate", may_rd[2], 32'h0);

    // R12 tRAS of 28.6 ns rounds up to 12 clocks
    issue(K_RRD - 1, 3'd1, 2'd3, 1'b0, 1'b0, "R5 activate bank 3 at tRRD");
    issue(K_RAS - 2, 3'd4, 2'd3, 1'b0, 1'b1, "R12 precharge one clock before rounded tRAS");
    issue(0, 3'd4, 2'd3, 1'b0, 1'b0, "R12 precharge at rounded tRAS");

    // R10 refresh cadence from reset, then from an accepted refresh
    do_reset();
    count_to_pulse("R10 first pulse after reset");
    issue(98, 3'd5, 2'd0, 1'b0, 1'b0, "R10 refresh accepted");
    count_to_pulse("R10 pulse after refresh command");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule